// File: doc/BRIEF.md
# Supply Fault Supervisor Output Controller

This block turns already-synchronized, per-cycle comparator decisions about one monitored supply into two reset outputs. The first output is an active-low under-voltage reset. The second is an active-low over-voltage reset, which also has an active-high copy. Each output is asserted while its fault is present. After the fault clears, the output stays asserted for a programmable number of clock cycles. If the fault comes back before that count is complete, the count starts again from zero.

The over-voltage channel can latch. While the latch-control input is low, a detected over-voltage keeps its output asserted until latch-control is driven high. A supply-lockout flag forces the under-voltage output asserted and holds the over-voltage output cleared. A disable input silences both outputs, except that lockout still reaches the under-voltage output. A bypass strap removes the hold-off count entirely.

Top module: `supply_fault_supervisor`

## Requirements
- R1: When `uv_flag` is sampled high with `out_disable` low, `uv_n` is 0 after that clock edge.
- R2: After the under-voltage fault clears, `uv_n` stays 0 and returns to 1 at the T-th consecutive edge at which the fault is absent. T is `hold_cycles`, and a value of 0 acts as 1.
- R3: If the fault returns while the hold-off count is running, the count restarts. Release then comes T edges after the last fault-free edge sequence begins.
- R4: With `tmr_bypass` high, each output releases at the first edge at which its fault is absent.
- R5: With `latch_ctl` low, a detected over-voltage keeps `ov_n` at 0 indefinitely after the fault clears. Driving `latch_ctl` high with no fault present releases it at the next edge.
- R6: With `latch_ctl` high, `ov_n` follows the same restartable T-edge hold-off as `uv_n`.
- R7: Driving `latch_ctl` low while the over-voltage hold-off is still running latches `ov_n` at 0.
- R8: While `lockout` is high, `uv_n` is 0 and `ov_n` is 1 even when `ov_flag` is high. After lockout ends, `uv_n` releases after the T-edge hold-off.
- R9: With `out_disable` high, `uv_n` and `ov_n` are 1 whatever the fault flags are. `lockout` still drives `uv_n` to 0, and `uv_n` returns to 1 at the first edge after lockout ends.
- R10: `ov_p` is always the inverse of `ov_n`.
- R11: A synchronous high `rst` gives `uv_n`=0, `ov_n`=1 and `ov_p`=0. After `rst` falls, `uv_n` releases after the T-edge hold-off.
- R12: Simultaneous under- and over-voltage faults are timed independently, with separate counters and no priority between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset into the lockout state |
| uv_flag | input | 1 | Under-voltage condition present |
| ov_flag | input | 1 | Over-voltage condition present |
| lockout | input | 1 | Supply too low for valid decisions |
| latch_ctl | input | 1 | Low: latch OV; high: clear latch and run OV on the hold-off |
| out_disable | input | 1 | Suppress both outputs (lockout still forces UV) |
| tmr_bypass | input | 1 | Release outputs without hold-off |
| hold_cycles | input | CW | Hold-off length in clock cycles (0 treated as 1) |
| uv_n | output | 1 | Active-low under-voltage reset |
| ov_n | output | 1 | Active-low over-voltage reset |
| ov_p | output | 1 | Active-high over-voltage reset |

## Verification
A corrupted hold-off counter or a stale latch bit shows up as a wrong release edge. The output rises earlier or later than the T-th fault-free edge, and this is visible within T+1 cycles of the fault clearing. The bench measures that release edge directly for a sweep of hold-off lengths and pulse widths on both channels. A wrong blocking or forcing decision, from lockout, disable or reset, shows on the very next edge, so those cases are sampled one cycle after the stimulus.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    // per-channel steering decided from the block inputs
    typedef struct packed {
        logic fault;   // condition present: assert and zero the count
        logic block;   // force inactive and clear all state
        logic bypass;  // release without hold-off
        logic hold;    // latch the channel while active
    } chan_ctl_t;

    localparam int NUM_CH = 2;
    localparam int CH_UV  = 0;
    localparam int CH_OV  = 1;
endpackage

// File: rtl/sfs_ctl_decode.sv
module sfs_ctl_decode
    import sfs_pkg::*;
(
    input  logic      uv_flag,
    input  logic      ov_flag,
    input  logic      lockout,
    input  logic      latch_ctl,
    input  logic      out_disable,
    input  logic      tmr_bypass,
    output chan_ctl_t uv_ctl,
    output chan_ctl_t ov_ctl
);
    always_comb begin
        // UV: lockout always forces it; disable masks the flag and skips the hold-off
        uv_ctl.fault  = lockout | (uv_flag & ~out_disable);
        uv_ctl.block  = 1'b0;
        uv_ctl.bypass = tmr_bypass | out_disable;
        uv_ctl.hold   = 1'b0;

        // OV: lockout and disable clear and block it; latch when latch_ctl low
        ov_ctl.fault  = ov_flag;
        ov_ctl.block  = lockout | out_disable;
        ov_ctl.bypass = tmr_bypass;
        ov_ctl.hold   = ~latch_ctl;
    end
endmodule

// File: rtl/sfs_hold_channel.sv
module sfs_hold_channel
    import sfs_pkg::*;
#(
    parameter int CW         = 16,
    parameter bit RST_ACTIVE = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  chan_ctl_t     ctl,
    input  logic [CW-1:0] limit,
    output logic          active
);
    localparam int EW = CW + 1;

    typedef struct packed {
        logic          active;
        logic          latched;
        logic [CW-1:0] cnt;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic [EW-1:0] cnt_inc_d;
    logic [EW-1:0] limit_eff_d;

    always_comb begin
        cnt_inc_d   = {1'b0, st_q.cnt} + EW'(1);
        limit_eff_d = (limit == '0) ? EW'(1) : {1'b0, limit};
        st_d        = st_q;
        if (ctl.block) begin
            st_d = '0;
        end else if (ctl.fault) begin
            st_d.active  = 1'b1;
            st_d.latched = ctl.hold;
            st_d.cnt     = '0;
        end else if (st_q.active) begin
            if (ctl.hold) begin
                st_d.latched = 1'b1;
                st_d.cnt     = '0;
            end else if (st_q.latched || ctl.bypass || (cnt_inc_d >= limit_eff_d)) begin
                st_d = '0;
            end else begin
                st_d.cnt = cnt_inc_d[CW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.active  <= RST_ACTIVE;
            st_q.latched <= 1'b0;
            st_q.cnt     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;
endmodule

// File: rtl/supply_fault_supervisor.sv
module supply_fault_supervisor
    import sfs_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          uv_flag,
    input  logic          ov_flag,
    input  logic          lockout,
    input  logic          latch_ctl,
    input  logic          out_disable,
    input  logic          tmr_bypass,
    input  logic [CW-1:0] hold_cycles,
    output logic          uv_n,
    output logic          ov_n,
    output logic          ov_p
);
    chan_ctl_t          ctl [NUM_CH];
    logic [NUM_CH-1:0]  ch_active;

    sfs_ctl_decode u_dec (
        .uv_flag     (uv_flag),
        .ov_flag     (ov_flag),
        .lockout     (lockout),
        .latch_ctl   (latch_ctl),
        .out_disable (out_disable),
        .tmr_bypass  (tmr_bypass),
        .uv_ctl      (ctl[CH_UV]),
        .ov_ctl      (ctl[CH_OV])
    );

    // reset lands in lockout: UV channel starts active, OV channel cleared
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        sfs_hold_channel #(
            .CW         (CW),
            .RST_ACTIVE (ch == CH_UV)
        ) u_ch (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl[ch]),
            .limit  (hold_cycles),
            .active (ch_active[ch])
        );
    end

    assign uv_n = ~ch_active[CH_UV];
    assign ov_n = ~ch_active[CH_OV];
    assign ov_p =  ch_active[CH_OV];
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker (
    input logic clk,
    input logic rst,
    input logic uv_flag,
    input logic ov_flag,
    input logic lockout,
    input logic latch_ctl,
    input logic out_disable,
    input logic tmr_bypass,
    input logic uv_n,
    input logic ov_n,
    input logic ov_p
);
    // R1
    uv_assert_chk: assert property (@(posedge clk) disable iff (rst)
        (uv_flag && !out_disable) |=> !uv_n);

    // R4
    bypass_release_chk: assert property (@(posedge clk) disable iff (rst)
        (tmr_bypass && !uv_flag && !lockout) |=> uv_n);

    // R5
    ov_latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ov_n && !latch_ctl && !lockout && !out_disable) |=> !ov_n);

    // R8
    lockout_force_chk: assert property (@(posedge clk) disable iff (rst)
        lockout |=> (!uv_n && ov_n));

    // R9
    disable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (out_disable && !lockout) |=> (uv_n && ov_n));

    // R12
    ov_independent_chk: assert property (@(posedge clk) disable iff (rst)
        (ov_flag && !lockout && !out_disable) |=> !ov_n);

    // R10
    ov_polarity_chk: assert property (@(posedge clk) disable iff (rst)
        ov_p != ov_n);
endmodule

bind supply_fault_supervisor sfs_checker u_sfs_chk (
    .clk         (clk),
    .rst         (rst),
    .uv_flag     (uv_flag),
    .ov_flag     (ov_flag),
    .lockout     (lockout),
    .latch_ctl   (latch_ctl),
    .out_disable (out_disable),
    .tmr_bypass  (tmr_bypass),
    .uv_n        (uv_n),
    .ov_n        (ov_n),
    .ov_p        (ov_p)
);

// File: tb/supply_fault_supervisor_test.sv
`timescale 1ns/1ps
module supply_fault_supervisor_test;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          uv_flag, ov_flag, lockout, latch_ctl, out_disable, tmr_bypass;
    logic [CW-1:0] hold_cycles;
    logic          uv_n, ov_n, ov_p;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    supply_fault_supervisor #(.CW(CW)) uut (
        .clk(clk), .rst(rst), .uv_flag(uv_flag), .ov_flag(ov_flag),
        .lockout(lockout), .latch_ctl(latch_ctl), .out_disable(out_disable),
        .tmr_bypass(tmr_bypass), .hold_cycles(hold_cycles),
        .uv_n(uv_n), .ov_n(ov_n), .ov_p(ov_p)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // edges until the chosen output first reads 1 (0 if never within 64)
    task automatic rel(input bit pick_ov, output int k);
        k = 0;
        for (int i = 1; i <= 64; i++) begin
            @(negedge clk);
            if ((pick_ov ? ov_n : uv_n) === 1'b1) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic quiesce();
        uv_flag = 0; ov_flag = 0; lockout = 0; out_disable = 0;
        tmr_bypass = 0; latch_ctl = 1;
        cyc(70);
    endtask

    initial begin
        int k;
        rst = 1; uv_flag = 0; ov_flag = 0; lockout = 0; latch_ctl = 1;
        out_disable = 0; tmr_bypass = 0; hold_cycles = 3;
        cyc(3);
        chk("R11 uv_n in reset", uv_n, 0);
        chk("R11 ov_n in reset", ov_n, 1);
        chk("R11 ov_p in reset", ov_p, 0);
        rst = 0;
        rel(0, k);
        chk("R11 uv release after reset", k, 3);

        // R2 / R1 / R6 / R10 sweep over hold-off length and pulse width
        for (int t = 0; t <= 8; t++) begin
            for (int len = 1; len <= 3; len++) begin
                hold_cycles = CW'(t);
                uv_flag = 1; cyc(len);
                chk("R1 uv asserted", uv_n, 0);
                uv_flag = 0;
                rel(0, k);
                chk("R2 uv release edge", k, (t == 0) ? 1 : t);
                ov_flag = 1; cyc(len);
                chk("R6 ov asserted", ov_n, 0);
                chk("R10 ov_p high", ov_p, 1);
                ov_flag = 0;
                rel(1, k);
                chk("R6 ov release edge", k, (t == 0) ? 1 : t);
                chk("R10 ov_p low", ov_p, 0);
            end
        end

        // R3 restart
        hold_cycles = 5;
        uv_flag = 1; cyc(1);
        uv_flag = 0; cyc(3);
        chk("R3 uv still low mid-count", uv_n, 0);
        uv_flag = 1; cyc(1);
        uv_flag = 0;
        rel(0, k);
        chk("R3 uv release after restart", k, 5);

        // R4 bypass
        hold_cycles = 6; tmr_bypass = 1;
        uv_flag = 1; ov_flag = 1; cyc(2);
        uv_flag = 0; ov_flag = 0; cyc(1);
        chk("R4 uv released at once", uv_n, 1);
        chk("R4 ov released at once", ov_n, 1);
        tmr_bypass = 0;

        // R5 latch then clear
        latch_ctl = 0;
        ov_flag = 1; cyc(1);
        ov_flag = 0; cyc(20);
        chk("R5 ov held by latch", ov_n, 0);
        latch_ctl = 1; cyc(1);
        chk("R5 ov cleared by latch_ctl", ov_n, 1);

        // R7 latch_ctl low during hold-off
        hold_cycles = 6;
        ov_flag = 1; cyc(1);
        ov_flag = 0; cyc(2);
        latch_ctl = 0; cyc(10);
        chk("R7 ov latched mid-count", ov_n, 0);
        latch_ctl = 1; cyc(1);
        chk("R7 ov cleared", ov_n, 1);

        // R8 lockout
        hold_cycles = 4;
        lockout = 1; ov_flag = 1; cyc(3);
        chk("R8 uv forced", uv_n, 0);
        chk("R8 ov blocked", ov_n, 1);
        lockout = 0; ov_flag = 0;
        rel(0, k);
        chk("R8 uv release after lockout", k, 4);
        quiesce();

        // R9 disable
        hold_cycles = 6;
        out_disable = 1; uv_flag = 1; ov_flag = 1; cyc(3);
        chk("R9 uv quiet", uv_n, 1);
        chk("R9 ov quiet", ov_n, 1);
        lockout = 1; cyc(2);
        chk("R9 uv forced by lockout", uv_n, 0);
        lockout = 0;
        rel(0, k);
        chk("R9 uv immediate release", k, 1);
        quiesce();

        // R12 independent channels
        hold_cycles = 3;
        uv_flag = 1; ov_flag = 1; cyc(2);
        ov_flag = 0; cyc(3);
        chk("R12 ov released alone", ov_n, 1);
        chk("R12 uv still asserted", uv_n, 0);
        uv_flag = 0;
        rel(0, k);
        chk("R12 uv own release", k, 3);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule